// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit turns one decoded operand specifier into either a register operand or the effective memory address of a memory operand. A specifier carries a 3-bit addressing mode, a base register number, an index register number with an enable bit, a displacement with its stored width, and a 2-bit operand size. The unit owns a small register file. Auto-modifying modes update the base register as part of the same operation. When a mode needs a pointer from memory, the unit issues a word read over a valid/ready request channel and waits for the response.

Mode encoding on `mode_i`:
- 0: register.
- 1: register deferred.
- 2: autoincrement.
- 3: autodecrement.
- 4: autoincrement deferred.
- 5: displacement.
- 6: displacement deferred.
- 7: illegal.

Operand size `size_i` = s selects 2^s bytes, that is 1, 2, 4 or 8. The pointer size is XLEN/8 bytes, which is 4 at the default. A loading port fills registers before use. If both write paths target a register in the same cycle, the unit's own write-back wins.

Top module: `opnd_agu`

## Requirements
- R1: After reset `done_o`, `fault_o`, `is_reg_o`, `busy_o` and `mem_req_valid_o` are 0.
- R2: In mode 0, one cycle after `start_i`, `done_o`=1, `is_reg_o`=1 and `operand_o` holds the base register contents. No memory request is made.
- R3: In mode 1, `operand_o` is the base register contents as an address, with `is_reg_o`=0.
- R4: In mode 2, the address is the old base value. The base register becomes base + 2^size.
- R5: In mode 3, the base register becomes base - 2^size, and that new value is the address.
- R6: In mode 5, the displacement is sign-extended from bit 7 when `disp_sz_i`=0, from bit 15 when it is 1, and used as 32 bits when it is 2 or 3. The result is added to the base register.
- R7: In mode 4, a pointer is read at the base value and becomes the address. The base register grows by 4 when `done_o` rises.
- R8: In mode 6, the pointer is read at base + sign-extended displacement. The read data, plus the scaled index when indexing is enabled, is the final address.
- R9: With `indexed_i`=1 in any memory mode, index register << size is added to the address the primary mode produced. The index value used is the one before this specifier's write-back.
- R10: A pointer request holds `mem_req_valid_o` and a stable `mem_req_addr_o` until `mem_req_ready_i`. `busy_o` stays 1 until the response. `done_o` rises for one cycle in the cycle after the response is taken.
- R11: Mode 0 with `indexed_i`=1, or mode 7, gives `done_o`=1 and `fault_o`=1 for one cycle. It writes no register and makes no memory request.
- R12: For non-deferred modes, write-back takes effect in the cycle `done_o` is high. A specifier started in that cycle is accepted and sees the updated register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Specifier valid; accepted when not busy |
| mode_i | input | 3 | Addressing mode |
| indexed_i | input | 1 | Add scaled index register |
| base_i | input | 3 | Base register number |
| index_i | input | 3 | Index register number |
| disp_i | input | 32 | Displacement, low bits significant per disp_sz_i |
| disp_sz_i | input | 2 | Displacement stored width |
| size_i | input | 2 | Operand size, 2^size bytes |
| rf_ld_en_i | input | 1 | Register load strobe |
| rf_ld_sel_i | input | 3 | Register load number |
| rf_ld_data_i | input | 32 | Register load value |
| mem_req_valid_o | output | 1 | Pointer read request |
| mem_req_ready_i | input | 1 | Request accepted |
| mem_req_addr_o | output | 32 | Pointer location |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Pointer value |
| busy_o | output | 1 | Pointer sequence in progress |
| done_o | output | 1 | Result valid, one cycle |
| is_reg_o | output | 1 | operand_o is register contents |
| fault_o | output | 1 | Illegal specifier |
| operand_o | output | 32 | Register operand or effective address |

## Verification
A walked sequence of non-deferred specifiers reuses one base register across autoincrement and autodecrement of several sizes. A wrong step size or the wrong update order therefore shows up in every later address. Displacements are chosen with their sign bit set and clear at each stored width, so truncation and sign extension can be told apart. Index scaling is tried at sizes 0, 2 and 3. Deferred modes run against a slow memory that holds ready low and delays the response, which exposes early completion or a wandering request address. Back-to-back and faulting specifiers show whether write-back is visible at once and whether an illegal mode leaves registers untouched.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_REG          = 3'd0,
    AM_REG_DEF      = 3'd1,
    AM_AUTO_INC     = 3'd2,
    AM_AUTO_DEC     = 3'd3,
    AM_AUTO_INC_DEF = 3'd4,
    AM_DISP         = 3'd5,
    AM_DISP_DEF     = 3'd6,
    AM_BAD          = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } agu_state_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  ra_a_i,
  output logic [XLEN-1:0] rd_a_o,
  input  logic [RAW-1:0]  ra_b_i,
  output logic [XLEN-1:0] rd_b_o,
  input  logic            ld_we_i,
  input  logic [RAW-1:0]  ld_sel_i,
  input  logic [XLEN-1:0] ld_data_i,
  input  logic            wb_we_i,
  input  logic [RAW-1:0]  wb_sel_i,
  input  logic [XLEN-1:0] wb_data_i
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs[g] <= '0;
      else if (wb_we_i && wb_sel_i == RAW'(g))    regs[g] <= wb_data_i;  // internal write wins
      else if (ld_we_i && ld_sel_i == RAW'(g))    regs[g] <= ld_data_i;
    end
  end

  assign rd_a_o = regs[ra_a_i];
  assign rd_b_o = regs[ra_b_i];
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
  import agu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PTR_BYTES = XLEN / 8
) (
  input  amode_e          mode_i,
  input  logic            indexed_i,
  input  logic [XLEN-1:0] base_val_i,
  input  logic [XLEN-1:0] idx_val_i,
  input  logic [XLEN-1:0] disp_i,
  input  logic [1:0]      disp_sz_i,
  input  logic [1:0]      size_i,
  output logic [XLEN-1:0] addr0_o,
  output logic [XLEN-1:0] idx_off_o,
  output logic            wb_en_o,
  output logic [XLEN-1:0] wb_val_o,
  output logic            deferred_o,
  output logic            reg_mode_o,
  output logic            illegal_o
);
  logic [XLEN-1:0] sz_bytes, disp_ext;

  assign sz_bytes = XLEN'(1) << size_i;

  always_comb begin
    case (disp_sz_i)
      2'd0:    disp_ext = {{(XLEN-8){disp_i[7]}}, disp_i[7:0]};
      2'd1:    disp_ext = {{(XLEN-16){disp_i[15]}}, disp_i[15:0]};
      default: disp_ext = disp_i;
    endcase
  end

  assign idx_off_o  = indexed_i ? (idx_val_i << size_i) : '0;
  assign reg_mode_o = (mode_i == AM_REG);
  assign deferred_o = (mode_i == AM_AUTO_INC_DEF) || (mode_i == AM_DISP_DEF);
  assign illegal_o  = (mode_i == AM_BAD) || (reg_mode_o && indexed_i);

  always_comb begin
    addr0_o  = base_val_i;
    wb_en_o  = 1'b0;
    wb_val_o = base_val_i;
    case (mode_i)
      AM_AUTO_INC: begin
        wb_en_o  = 1'b1;
        wb_val_o = base_val_i + sz_bytes;
      end
      AM_AUTO_DEC: begin
        addr0_o  = base_val_i - sz_bytes;  // pre-decrement
        wb_en_o  = 1'b1;
        wb_val_o = base_val_i - sz_bytes;
      end
      AM_AUTO_INC_DEF: begin
        wb_en_o  = 1'b1;
        wb_val_o = base_val_i + XLEN'(PTR_BYTES);
      end
      AM_DISP, AM_DISP_DEF: addr0_o = base_val_i + disp_ext;
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd_agu.sv
module opnd_agu
  import agu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      mode_i,
  input  logic            indexed_i,
  input  logic [RAW-1:0]  base_i,
  input  logic [RAW-1:0]  index_i,
  input  logic [XLEN-1:0] disp_i,
  input  logic [1:0]      disp_sz_i,
  input  logic [1:0]      size_i,
  input  logic            rf_ld_en_i,
  input  logic [RAW-1:0]  rf_ld_sel_i,
  input  logic [XLEN-1:0] rf_ld_data_i,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [XLEN-1:0] mem_req_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [XLEN-1:0] mem_rsp_data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            is_reg_o,
  output logic            fault_o,
  output logic [XLEN-1:0] operand_o
);
  agu_state_e      state_q;
  logic [XLEN-1:0] base_val, idx_val, addr0, idx_off, wb_val;
  logic            wb_en, deferred, reg_mode, illegal;
  logic [XLEN-1:0] ptr_addr_q, idx_off_q, wb_val_q, operand_q;
  logic [RAW-1:0]  wb_sel_q;
  logic            wb_en_q, done_q, fault_q, is_reg_q;
  logic            accept, rsp_take, int_we;
  logic [RAW-1:0]  int_sel;
  logic [XLEN-1:0] int_val;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign rsp_take = (state_q == ST_WAIT) && mem_rsp_valid_i;
  assign int_we   = (accept && !illegal && !deferred && wb_en) || (rsp_take && wb_en_q);
  assign int_sel  = rsp_take ? wb_sel_q : base_i;
  assign int_val  = rsp_take ? wb_val_q : wb_val;

  agu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_a_i(base_i), .rd_a_o(base_val),
    .ra_b_i(index_i), .rd_b_o(idx_val),
    .ld_we_i(rf_ld_en_i), .ld_sel_i(rf_ld_sel_i), .ld_data_i(rf_ld_data_i),
    .wb_we_i(int_we), .wb_sel_i(int_sel), .wb_data_i(int_val)
  );

  agu_ea_calc #(.XLEN(XLEN)) u_ea (
    .mode_i(amode_e'(mode_i)), .indexed_i, .base_val_i(base_val), .idx_val_i(idx_val),
    .disp_i, .disp_sz_i, .size_i,
    .addr0_o(addr0), .idx_off_o(idx_off), .wb_en_o(wb_en), .wb_val_o(wb_val),
    .deferred_o(deferred), .reg_mode_o(reg_mode), .illegal_o(illegal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ptr_addr_q <= '0;
      idx_off_q  <= '0;
      wb_val_q   <= '0;
      wb_sel_q   <= '0;
      wb_en_q    <= 1'b0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      is_reg_q   <= 1'b0;
      operand_q  <= '0;
    end else begin
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      is_reg_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (illegal) begin
            done_q    <= 1'b1;
            fault_q   <= 1'b1;
            operand_q <= '0;
          end else if (deferred) begin
            ptr_addr_q <= addr0;
            idx_off_q  <= idx_off;
            wb_val_q   <= wb_val;
            wb_sel_q   <= base_i;
            wb_en_q    <= wb_en;
            state_q    <= ST_REQ;
          end else begin
            done_q    <= 1'b1;
            is_reg_q  <= reg_mode;
            operand_q <= reg_mode ? base_val : addr0 + idx_off;
          end
        end
        ST_REQ: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          done_q    <= 1'b1;
          operand_q <= mem_rsp_data_i + idx_off_q;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = ptr_addr_q;
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = done_q;
  assign fault_o         = fault_q;
  assign is_reg_o        = is_reg_q;
  assign operand_o       = operand_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_valid_o); // R10
  AST_RSP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_req_valid_o && mem_rsp_valid_i |=> done_o && !busy_o); // R10
  AST_FAULT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o && !is_reg_o && !busy_o); // R11
  AST_ISREG_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_reg_o |-> done_o); // R2
  AST_START_PROGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> done_o || busy_o); // R12
endmodule

// File: tb/opnd_agu_test.sv
`timescale 1ns/1ps
module opnd_agu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, indexed = 1'b0;
  logic [2:0]  mode = '0, base = '0, index = '0, ld_sel = '0;
  logic [31:0] disp = '0, ld_data = '0, rsp_data = '0;
  logic [1:0]  dsz = '0, size = '0;
  logic        ld_en = 1'b0, req_ready = 1'b0, rsp_valid = 1'b0;
  logic        req_valid, busy, done, is_reg, fault;
  logic [31:0] req_addr, operand;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  opnd_agu uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .indexed_i(indexed),
    .base_i(base), .index_i(index), .disp_i(disp), .disp_sz_i(dsz), .size_i(size),
    .rf_ld_en_i(ld_en), .rf_ld_sel_i(ld_sel), .rf_ld_data_i(ld_data),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .busy_o(busy), .done_o(done), .is_reg_o(is_reg), .fault_o(fault), .operand_o(operand)
  );

  typedef struct packed {
    logic [2:0]  md;
    logic        ix;
    logic [2:0]  b;
    logic [2:0]  x;
    logic [31:0] d;
    logic [1:0]  ds;
    logic [1:0]  sz;
    logic [31:0] exp;
    logic        isr;
  } vec_t;

  // regs: r1=1000 r2=2000 r3=3 r4=4000 r5=500 r6=FFFFFFF0 r7=7000
  localparam vec_t VEC [13] = '{
    '{3'd0, 1'b0, 3'd1, 3'd0, 32'h0,         2'd0, 2'd0, 32'h0000_1000, 1'b1}, // R2
    '{3'd1, 1'b0, 3'd2, 3'd0, 32'h0,         2'd0, 2'd0, 32'h0000_2000, 1'b0}, // R3
    '{3'd1, 1'b1, 3'd2, 3'd3, 32'h0,         2'd0, 2'd2, 32'h0000_200C, 1'b0}, // R9
    '{3'd2, 1'b0, 3'd4, 3'd0, 32'h0,         2'd0, 2'd2, 32'h0000_4000, 1'b0}, // R4
    '{3'd2, 1'b0, 3'd4, 3'd0, 32'h0,         2'd0, 2'd3, 32'h0000_4004, 1'b0}, // R4
    '{3'd3, 1'b0, 3'd4, 3'd0, 32'h0,         2'd0, 2'd1, 32'h0000_400A, 1'b0}, // R5
    '{3'd3, 1'b1, 3'd4, 3'd3, 32'h0,         2'd0, 2'd0, 32'h0000_400C, 1'b0}, // R5 R9
    '{3'd0, 1'b0, 3'd4, 3'd0, 32'h0,         2'd0, 2'd0, 32'h0000_4009, 1'b1}, // R5
    '{3'd5, 1'b0, 3'd5, 3'd0, 32'h0000_0080, 2'd0, 2'd0, 32'h0000_0480, 1'b0}, // R6
    '{3'd5, 1'b0, 3'd5, 3'd0, 32'h0000_007F, 2'd0, 2'd0, 32'h0000_057F, 1'b0}, // R6
    '{3'd5, 1'b0, 3'd5, 3'd0, 32'h1234_8000, 2'd1, 2'd0, 32'hFFFF_8500, 1'b0}, // R6
    '{3'd5, 1'b1, 3'd5, 3'd3, 32'h0000_0100, 2'd2, 2'd3, 32'h0000_0618, 1'b0}, // R6 R9
    '{3'd5, 1'b0, 3'd6, 3'd0, 32'h0000_0020, 2'd0, 2'd0, 32'h0000_0010, 1'b0}  // R6
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] r, input logic [31:0] v);
    @(negedge clk); ld_en = 1'b1; ld_sel = r; ld_data = v;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic drive(input logic [2:0] m, input logic ix, input logic [2:0] b, input logic [2:0] x,
                       input logic [31:0] d, input logic [1:0] ds, input logic [1:0] sz);
    start = 1'b1; mode = m; indexed = ix; base = b; index = x; disp = d; dsz = ds; size = sz;
  endtask

  // one non-deferred specifier; samples in the done cycle
  task automatic run_nd(input logic [2:0] m, input logic ix, input logic [2:0] b, input logic [2:0] x,
                        input logic [31:0] d, input logic [1:0] ds, input logic [1:0] sz,
                        output logic [31:0] res, output logic ok_flags, input logic exp_isr);
    @(negedge clk); drive(m, ix, b, x, d, ds, sz);
    @(negedge clk); start = 1'b0;
    res = operand;
    ok_flags = done && !fault && (is_reg == exp_isr) && !req_valid;
  endtask

  // deferred specifier against a slow memory
  task automatic run_def(input logic [2:0] m, input logic ix, input logic [2:0] b, input logic [2:0] x,
                         input logic [31:0] d, input logic [1:0] ds, input logic [1:0] sz,
                         input logic [31:0] exp_ptr, input logic [31:0] mem_val, input logic [31:0] exp_op,
                         input string req);
    @(negedge clk); drive(m, ix, b, x, d, ds, sz);
    @(negedge clk); start = 1'b0;
    chk(req_valid && busy && !done && req_addr == exp_ptr, req, req_addr, exp_ptr);
    @(negedge clk);
    chk(req_valid && req_addr == exp_ptr, "R10 hold", req_addr, exp_ptr);
    req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    chk(!req_valid && busy && !done, "R10 wait", {29'd0, req_valid, busy, done}, 32'h2);
    @(negedge clk); rsp_valid = 1'b1; rsp_data = mem_val;
    @(negedge clk); rsp_valid = 1'b0; rsp_data = '0;
    chk(done && !busy && !is_reg && operand == exp_op, req, operand, exp_op);
    @(negedge clk);
    chk(!done, "R10 pulse", {31'd0, done}, 32'h0);
  endtask

  initial begin
    logic [31:0] r;
    logic ok;
    #55 rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !fault && !is_reg && !busy && !req_valid, "R1 reset",
        {27'd0, done, fault, is_reg, busy, req_valid}, 32'h0);
    load(3'd1, 32'h1000); load(3'd2, 32'h2000); load(3'd3, 32'h3);
    load(3'd4, 32'h4000); load(3'd5, 32'h500);  load(3'd6, 32'hFFFF_FFF0);
    load(3'd7, 32'h7000);

    for (int i = 0; i < 13; i++) begin
      run_nd(VEC[i].md, VEC[i].ix, VEC[i].b, VEC[i].x, VEC[i].d, VEC[i].ds, VEC[i].sz,
             r, ok, VEC[i].isr);
      chk(ok && r == VEC[i].exp, $sformatf("R2-table vector %0d", i), r, VEC[i].exp);
    end

    // R11: indexed register mode and mode 7 fault, no write, no request
    @(negedge clk); drive(3'd0, 1'b1, 3'd1, 3'd3, 32'h0, 2'd0, 2'd2);
    @(negedge clk); start = 1'b0;
    chk(done && fault && !is_reg && !req_valid && !busy, "R11 fault idx reg",
        {28'd0, done, fault, is_reg, req_valid}, 32'hC);
    @(negedge clk);
    chk(!done && !fault, "R11 pulse", {30'd0, done, fault}, 32'h0);
    @(negedge clk); drive(3'd7, 1'b0, 3'd4, 3'd0, 32'h0, 2'd0, 2'd2);
    @(negedge clk); start = 1'b0;
    chk(done && fault && !req_valid, "R11 fault mode7", {30'd0, done, fault}, 32'h3);
    run_nd(3'd0, 1'b0, 3'd4, 3'd0, 32'h0, 2'd0, 2'd0, r, ok, 1'b1);
    chk(ok && r == 32'h4009, "R11 r4 unchanged", r, 32'h4009);
    run_nd(3'd0, 1'b0, 3'd1, 3'd0, 32'h0, 2'd0, 2'd0, r, ok, 1'b1);
    chk(ok && r == 32'h1000, "R11 r1 unchanged", r, 32'h1000);

    // R12: back-to-back, second specifier sees autoincremented r1
    @(negedge clk); drive(3'd2, 1'b0, 3'd1, 3'd0, 32'h0, 2'd0, 2'd0);
    @(negedge clk);
    chk(done && operand == 32'h1000, "R12 first", operand, 32'h1000);
    drive(3'd0, 1'b0, 3'd1, 3'd0, 32'h0, 2'd0, 2'd0);
    @(negedge clk); start = 1'b0;
    chk(done && is_reg && operand == 32'h1001, "R12 second", operand, 32'h1001);

    // R7: autoincrement deferred, indexed size 1 with r3=3
    run_def(3'd4, 1'b1, 3'd7, 3'd3, 32'h0, 2'd0, 2'd1, 32'h7000, 32'h9000, 32'h9006, "R7 R9");
    run_nd(3'd0, 1'b0, 3'd7, 3'd0, 32'h0, 2'd0, 2'd0, r, ok, 1'b1);
    chk(ok && r == 32'h7004, "R7 base +4", r, 32'h7004);

    // R8: displacement deferred, byte disp F0 = -16
    run_def(3'd6, 1'b0, 3'd2, 3'd0, 32'h0000_00F0, 2'd0, 2'd0, 32'h1FF0, 32'hABC0, 32'hABC0, "R8");
    run_def(3'd6, 1'b1, 3'd2, 3'd3, 32'h0000_0010, 2'd0, 2'd3, 32'h2010, 32'h100, 32'h118, "R8 R9 idx");
    run_nd(3'd0, 1'b0, 3'd2, 3'd0, 32'h0, 2'd0, 2'd0, r, ok, 1'b1);
    chk(ok && r == 32'h2000, "R8 base unchanged", r, 32'h2000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule